// File: doc/BRIEF.md
# Cut-Through Transmit Block Queue

This block sits between a host-side byte stream and a network MAC transmitter. Frame bytes arrive on a byte-wide write port with start-of-frame and end-of-frame markers. They are stored in an internal memory that is carved into a fixed number of block slots. A frame always starts in a fresh slot. A block is complete once it holds the configured number of bytes, or once it receives the frame's last byte.

The MAC side is a byte-wide valid/ready read stream. A frame becomes eligible for transmit as soon as a programmable count of its blocks, from 1 to 4, is complete. If the frame ends before that count is reached, it becomes eligible when its last block is complete. The queue does not wait for the whole frame, so the MAC can start sending early. The reader hands out only bytes from complete blocks. It frees each slot after fetching that slot's last byte, and frames leave in the order they arrived.

Two settings are held in configuration registers: the block size and the start threshold. Once the sync input has been seen high, both settings are frozen until reset. The block size must equal the payload size of each host transfer chunk. `BLK_MAX` must be a power of two.

Top module: `ctq_top`

## Requirements
- R1: After reset, `wr_ready` is 1 and `rd_valid` is 0. The threshold resets to code 01 (2 blocks) and the block size resets to code 001 (`BLK_MAX` bytes).
- R2: The threshold code `cfg_thr` selects 1, 2, 3 or 4 blocks for codes 00, 01, 10 and 11. No byte of a frame appears on the read stream until that many of its blocks are complete.
- R3: The block-size code `cfg_bsz` selects `BLK_MAX/2` bytes for code 000 and `BLK_MAX` bytes for code 001. A block is complete after that many bytes, or at end of frame.
- R4: A configuration write carrying any other block-size code leaves the block size unchanged. The threshold in the same write still takes effect.
- R5: A frame whose end arrives before the threshold is reached becomes eligible once its last block is complete.
- R6: From the cycle after `sync` is seen high, configuration writes change neither setting. Only reset clears this lock.
- R7: `wr_ready` is 0 when the next byte needs a new block and all `NBLK` slots are allocated.
- R8: Bytes leave in arrival order, with `rd_eof` high on the last byte of each frame. A slot is freed after its last byte is fetched, which lets writing resume.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid`, `rd_data` and `rd_eof` hold their values.
- R10: A byte accepted outside a frame is discarded. A byte is outside a frame when it comes after an end of frame and does not carry `wr_sof`, or when it comes before any start of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thr | input | 2 | Start threshold code |
| cfg_bsz | input | 3 | Block size code |
| sync | input | 1 | Sets the configuration lock |
| wr_valid | input | 1 | Host byte valid |
| wr_ready | output | 1 | Queue can take the byte |
| wr_data | input | 8 | Host byte |
| wr_sof | input | 1 | Byte is the first of a frame |
| wr_eof | input | 1 | Byte is the last of a frame |
| rd_valid | output | 1 | Byte available to the MAC |
| rd_ready | input | 1 | MAC takes the byte |
| rd_data | output | 8 | Byte to the MAC |
| rd_eof | output | 1 | Byte is the last of its frame |

## Verification
On every cycle, the assertions check four things:
- the block counters never exceed the slot count, and complete blocks never outnumber allocated ones;
- the block-size register only ever holds a legal code;
- both settings stay frozen once the lock is set;
- the read stream holds steady under back-pressure.

Threshold timing can only be shown by the bench scenarios: a sweep of every threshold code against both block sizes, checked one byte before and one byte after the boundary. The scenarios also show early-end eligibility, the ignored reserved code, the lock and its release by reset, the full-queue stall with recovery, and discarding of stray bytes.

// File: rtl/ctq_pkg.sv
package ctq_pkg;
  localparam logic [2:0] BSZ_HALF = 3'b000;
  localparam logic [2:0] BSZ_FULL = 3'b001;
  localparam logic [1:0] THR_RST  = 2'b01;
endpackage

// File: rtl/ctq_cfg.sv
module ctq_cfg
  import ctq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_thr,
  input  logic [2:0] cfg_bsz,
  input  logic       sync,
  output logic [1:0] thr,
  output logic [2:0] bsz
);
  logic locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      thr    <= THR_RST;
      bsz    <= BSZ_FULL;
    end else begin
      if (sync) locked <= 1'b1;
      if (cfg_we && !locked) begin
        thr <= cfg_thr;
        if (cfg_bsz == BSZ_HALF || cfg_bsz == BSZ_FULL) bsz <= cfg_bsz;
      end
    end
  end

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(thr) && $stable(bsz))); // R6
  AST_BSZ_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (bsz == BSZ_HALF || bsz == BSZ_FULL)); // R4
endmodule

// File: rtl/ctq_ram.sv
module ctq_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctq_wr.sv
module ctq_wr
  import ctq_pkg::*;
#(
  parameter int NBLK    = 8,
  parameter int BLK_MAX = 64,
  localparam int BW     = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int OFFW   = $clog2(BLK_MAX)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  input  logic [7:0]               wr_data,
  input  logic                     wr_sof,
  input  logic                     wr_eof,
  input  logic [2:0]               bsz,
  input  logic                     alloc_full,
  output logic                     wr_ready,
  output logic                     mem_we,
  output logic [BW+OFFW-1:0]       mem_waddr,
  output logic [7:0]               mem_wdata,
  output logic                     blk_new,
  output logic                     blk_done,
  output logic                     blk_done_eof,
  output logic [NBLK-1:0][OFFW:0]  meta
);
  localparam logic [OFFW-1:0] OFF_FULL = OFFW'(BLK_MAX - 1);
  localparam logic [OFFW-1:0] OFF_HALF = OFFW'(BLK_MAX / 2 - 1);

  logic [BW-1:0]   wblk;
  logic [OFFW-1:0] woff;
  logic            in_frame;
  logic [OFFW-1:0] last_off;
  logic            store, blk_end;

  assign last_off     = (bsz == BSZ_HALF) ? OFF_HALF : OFF_FULL;
  assign wr_ready     = !(woff == '0 && alloc_full);
  assign store        = wr_valid && wr_ready && (in_frame || wr_sof);
  assign blk_end      = store && (wr_eof || woff >= last_off);
  assign mem_we       = store;
  assign mem_waddr    = {wblk, woff};
  assign mem_wdata    = wr_data;
  assign blk_new      = store && (woff == '0);
  assign blk_done     = blk_end;
  assign blk_done_eof = blk_end && wr_eof;

  always_ff @(posedge clk) begin
    if (rst) begin
      wblk     <= '0;
      woff     <= '0;
      in_frame <= 1'b0;
      meta     <= '0;
    end else if (store) begin
      in_frame <= !wr_eof;
      if (blk_end) begin
        meta[wblk] <= {wr_eof, woff};
        wblk       <= (wblk == BW'(NBLK - 1)) ? '0 : wblk + BW'(1);
        woff       <= '0;
      end else begin
        woff <= woff + OFFW'(1);
      end
    end
  end
endmodule

// File: rtl/ctq_acct.sv
module ctq_acct #(
  parameter int NBLK = 8,
  localparam int CW  = $clog2(NBLK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_new,
  input  logic          blk_done,
  input  logic          blk_done_eof,
  input  logic          blk_free,
  input  logic          blk_free_eof,
  output logic          alloc_full,
  output logic [CW-1:0] done_cnt,
  output logic [CW-1:0] eof_cnt
);
  logic [CW-1:0] alloc_cnt;

  assign alloc_full = (alloc_cnt == CW'(NBLK));

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_cnt <= '0;
      done_cnt  <= '0;
      eof_cnt   <= '0;
    end else begin
      alloc_cnt <= alloc_cnt + CW'(blk_new) - CW'(blk_free);
      done_cnt  <= done_cnt + CW'(blk_done) - CW'(blk_free);
      eof_cnt   <= eof_cnt + CW'(blk_done_eof) - CW'(blk_free_eof);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    alloc_cnt <= CW'(NBLK)); // R7
  AST_DONE_LE_ALLOC: assert property (@(posedge clk) disable iff (rst)
    done_cnt <= alloc_cnt); // R8
  AST_EOF_LE_DONE: assert property (@(posedge clk) disable iff (rst)
    eof_cnt <= done_cnt); // R5
endmodule

// File: rtl/ctq_rd.sv
module ctq_rd #(
  parameter int NBLK    = 8,
  parameter int BLK_MAX = 64,
  localparam int BW     = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int OFFW   = $clog2(BLK_MAX),
  localparam int CW     = $clog2(NBLK + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_ready,
  input  logic [1:0]              thr,
  input  logic [CW-1:0]           done_cnt,
  input  logic [CW-1:0]           eof_cnt,
  input  logic [NBLK-1:0][OFFW:0] meta,
  output logic                    mem_re,
  output logic [BW+OFFW-1:0]      mem_raddr,
  output logic                    rd_valid,
  output logic                    rd_eof,
  output logic                    blk_free,
  output logic                    blk_free_eof
);
  logic            active;
  logic [BW-1:0]   rblk;
  logic [OFFW-1:0] roff;
  logic [OFFW:0]   cur;
  logic            is_last, fetch;

  assign cur          = meta[rblk];
  assign is_last      = (roff == cur[OFFW-1:0]);
  assign fetch        = active && (done_cnt != '0) && (!rd_valid || rd_ready);
  assign mem_re       = fetch;
  assign mem_raddr    = {rblk, roff};
  assign blk_free     = fetch && is_last;
  assign blk_free_eof = blk_free && cur[OFFW];

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      rblk     <= '0;
      roff     <= '0;
      rd_valid <= 1'b0;
      rd_eof   <= 1'b0;
    end else begin
      if (!active)
        active <= (int'(done_cnt) > int'(thr)) || (eof_cnt != '0);
      else if (blk_free_eof)
        active <= 1'b0;
      if (fetch) begin
        rd_valid <= 1'b1;
        rd_eof   <= blk_free_eof;
        if (is_last) begin
          roff <= '0;
          rblk <= (rblk == BW'(NBLK - 1)) ? '0 : rblk + BW'(1);
        end else begin
          roff <= roff + OFFW'(1);
        end
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctq_top.sv
module ctq_top #(
  parameter int NBLK    = 8,
  parameter int BLK_MAX = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_thr,
  input  logic [2:0] cfg_bsz,
  input  logic       sync,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       wr_sof,
  input  logic       wr_eof,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_eof
);
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int OFFW = $clog2(BLK_MAX);
  localparam int CW   = $clog2(NBLK + 1);
  localparam int AW   = BW + OFFW;

  logic [1:0]              thr;
  logic [2:0]              bsz;
  logic                    alloc_full;
  logic                    mem_we, mem_re;
  logic [AW-1:0]           mem_waddr, mem_raddr;
  logic [7:0]              mem_wdata;
  logic                    blk_new, blk_done, blk_done_eof;
  logic                    blk_free, blk_free_eof;
  logic [CW-1:0]           done_cnt, eof_cnt;
  logic [NBLK-1:0][OFFW:0] meta;

  ctq_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
    .cfg_bsz(cfg_bsz), .sync(sync), .thr(thr), .bsz(bsz)
  );

  ctq_wr #(.NBLK(NBLK), .BLK_MAX(BLK_MAX)) u_wr (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_sof(wr_sof), .wr_eof(wr_eof), .bsz(bsz), .alloc_full(alloc_full),
    .wr_ready(wr_ready), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .blk_new(blk_new), .blk_done(blk_done),
    .blk_done_eof(blk_done_eof), .meta(meta)
  );

  ctq_acct #(.NBLK(NBLK)) u_acct (
    .clk(clk), .rst(rst), .blk_new(blk_new), .blk_done(blk_done),
    .blk_done_eof(blk_done_eof), .blk_free(blk_free),
    .blk_free_eof(blk_free_eof), .alloc_full(alloc_full),
    .done_cnt(done_cnt), .eof_cnt(eof_cnt)
  );

  ctq_rd #(.NBLK(NBLK), .BLK_MAX(BLK_MAX)) u_rd (
    .clk(clk), .rst(rst), .rd_ready(rd_ready), .thr(thr),
    .done_cnt(done_cnt), .eof_cnt(eof_cnt), .meta(meta),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .rd_valid(rd_valid),
    .rd_eof(rd_eof), .blk_free(blk_free), .blk_free_eof(blk_free_eof)
  );

  ctq_ram #(.DW(8), .AW(AW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(rd_data)
  );

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_eof))); // R9
endmodule

// File: tb/ctq_top_bench.sv
module ctq_top_bench;
  localparam int NB = 8;
  localparam int BM = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cfg_we, sync, wr_valid, wr_ready, wr_sof, wr_eof;
  logic rd_valid, rd_ready, rd_eof;
  logic [1:0] cfg_thr;
  logic [2:0] cfg_bsz;
  logic [7:0] wr_data, rd_data;

  ctq_top #(.NBLK(NB), .BLK_MAX(BM)) u_ctq_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
    .cfg_bsz(cfg_bsz), .sync(sync), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_sof(wr_sof),
    .wr_eof(wr_eof), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_eof(rd_eof)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] got [0:255];
  bit geof [0:255];
  int gcnt;

  always @(negedge clk) begin
    if (!rst && rd_valid && rd_ready) begin
      if (gcnt < 256) begin
        got[gcnt]  = rd_data;
        geof[gcnt] = rd_eof;
      end
      gcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1; cfg_we = 0; cfg_thr = 0; cfg_bsz = 0; sync = 0;
    wr_valid = 0; wr_data = 0; wr_sof = 0; wr_eof = 0; rd_ready = 1;
    idle(3);
    rst = 0;
    gcnt = 0;
    for (int i = 0; i < 256; i++) geof[i] = 0;
  endtask

  task automatic cfg(input logic [1:0] t, input logic [2:0] b);
    cfg_we = 1; cfg_thr = t; cfg_bsz = b;
    idle(1);
    cfg_we = 0;
  endtask

  task automatic put(input logic [7:0] d, input bit s, input bit e);
    wr_valid = 1; wr_data = d; wr_sof = s; wr_eof = e;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    idle(1);
    wr_valid = 0; wr_sof = 0; wr_eof = 0;
  endtask

  task automatic send(input int from, input int upto, input int total, input int base);
    for (int i = from; i < upto; i++) put(8'(base + i), i == 0, i == total - 1);
  endtask

  task automatic verify(input int off, input int total, input int base, input string tag);
    int bad, first_act, first_exp, neof;
    bad = 0; first_act = 0; first_exp = 0; neof = 0;
    for (int i = 0; i < total; i++) begin
      if (got[off + i] !== 8'(base + i)) begin
        if (bad == 0) begin first_act = got[off + i]; first_exp = 8'(base + i); end
        bad++;
      end
      if (geof[off + i]) neof++;
    end
    chk(bad == 0, {tag, " R8 data order"}, first_act, first_exp);
    chk(geof[off + total - 1] && neof == 1, {tag, " R8 eof marker"}, neof, 1);
  endtask

  task automatic thr_case(input int t, input int b, input int blk, input string tag);
    int n, total;
    n = (t + 1) * blk;
    total = n + 3;
    send(0, n - 1, total, 16);
    idle(6);
    chk(gcnt == 0, {tag, " R2 no start below threshold"}, gcnt, 0);
    send(n - 1, n, total, 16);
    idle(6);
    chk(gcnt > 0, {tag, " R2 start at threshold"}, gcnt, 1);
    send(n, total, total, 16);
    idle(total + 10);
    chk(gcnt == total, {tag, " R3 byte count"}, gcnt, total);
    verify(0, total, 16, tag);
  endtask

  initial begin
    do_reset();
    // R1 reset state and defaults (2 blocks of BM bytes)
    chk(wr_ready == 1, "R1 wr_ready after reset", wr_ready, 1);
    chk(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
    thr_case(1, 1, BM, "R1 defaults");

    // R2 and R3 sweep over every threshold and both block sizes
    for (int t = 0; t < 4; t++)
      for (int b = 0; b < 2; b++) begin
        do_reset();
        cfg(2'(t), 3'(b));
        thr_case(t, b, (b == 0) ? BM / 2 : BM, $sformatf("R2 R3 thr=%0d bsz=%0d", t, b));
      end

    // R4 reserved block-size code ignored, threshold still written
    do_reset();
    cfg(2'b11, 3'b000);
    cfg(2'b00, 3'b111);
    thr_case(0, 0, BM / 2, "R4 reserved code");

    // R5 frame ends before threshold, then a short frame behind it
    do_reset();
    cfg(2'b11, 3'b001);
    send(0, 9, 10, 32);
    idle(6);
    chk(gcnt == 0, "R5 not eligible before eof", gcnt, 0);
    send(9, 10, 10, 32);
    idle(20);
    chk(gcnt == 10, "R5 early end eligible", gcnt, 10);
    send(0, 5, 5, 128);
    idle(20);
    chk(gcnt == 15, "R5 second short frame", gcnt, 15);
    verify(0, 10, 32, "R5 frame A");
    verify(10, 5, 128, "R5 frame B");

    // R6 lock freezes configuration; reset releases it
    do_reset();
    cfg(2'b00, 3'b000);
    sync = 1; idle(1); sync = 0;
    cfg(2'b11, 3'b001);
    thr_case(0, 0, BM / 2, "R6 locked");
    do_reset();
    cfg(2'b11, 3'b000);
    thr_case(3, 0, BM / 2, "R6 unlocked by reset");

    // R7 full stall, R9 hold under back-pressure, R8 freeing resumes writes
    do_reset();
    cfg(2'b00, 3'b000);
    rd_ready = 0;
    send(0, NB * BM / 2, NB * BM / 2 + 4, 64);
    wr_valid = 1; wr_data = 8'(64 + NB * BM / 2); wr_sof = 0; wr_eof = 0;
    @(negedge clk);
    chk(wr_ready == 0, "R7 ready low when all slots used", wr_ready, 0);
    chk(rd_valid == 1 && rd_data == 8'd64, "R9 first byte presented", rd_data, 64);
    repeat (3) @(negedge clk);
    chk(wr_ready == 0, "R7 ready stays low", wr_ready, 0);
    chk(rd_valid == 1 && rd_data == 8'd64 && rd_eof == 0, "R9 byte held", rd_data, 64);
    idle(1);
    rd_ready = 1;
    send(NB * BM / 2, NB * BM / 2 + 4, NB * BM / 2 + 4, 64);
    idle(60);
    chk(gcnt == NB * BM / 2 + 4, "R8 all bytes after drain", gcnt, NB * BM / 2 + 4);
    verify(0, NB * BM / 2 + 4, 64, "R8 full drain");

    // R10 stray bytes outside a frame are dropped
    do_reset();
    cfg(2'b00, 3'b000);
    put(8'hEE, 0, 0);
    put(8'hEE, 0, 0);
    send(0, 6, 6, 64);
    put(8'hDD, 0, 0);
    send(0, 3, 3, 200);
    idle(30);
    chk(gcnt == 9, "R10 stray bytes discarded", gcnt, 9);
    verify(0, 6, 64, "R10 frame A");
    verify(6, 3, 200, "R10 frame B");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R8: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule